// File: doc/BRIEF.md
# Message-Framed Serial Receive Channel

This block is one asynchronous serial receive channel. It synchronises the incoming line and times bits from one of several reference tick strobes, divided by an even divisor. It detects a start bit, samples every bit at its middle, and assembles 8-bit characters sent LSB first. Each character has an optional parity bit and one or two stop bits.

Received characters are packed four to a 32-bit word and handed to an external receive FIFO. The first byte of a word lands in bits 7:0. The line is divided into messages. A message ends when the line stays idle for a programmable number of bit times after a stop bit. At that point the block does four things:
- It writes out any partly filled word, with the unused bytes set to zero.
- It latches the message length in bytes.
- It raises a done interrupt.
- It can drop its own enable, so that only one message is taken.

The block also reports, as a word count, the FIFO occupancy plus any words still held in its packing stage. An almost-full flag compares that count with a programmable level. An overflow interrupt fires when a word meets a full FIFO.

Top module: `msg_uart_rx`

## Requirements
- R1: After reset the receiver is disabled, `byte_count_o` is 0, all interrupt and error outputs are 0, and no FIFO write occurs.
- R2: Characters are taken LSB first. Four characters form one word, with the first in bits 7:0 and the fourth in bits 31:24. The word is written as a single-cycle `fifo_wr_o` pulse as soon as the fourth character completes.
- R3: When the line stays high for `gap_bits_i` bit times after the last stop bit of a message, a partly filled word is written with its unused upper bytes set to zero. If no bytes are pending, no extra word is written.
- R4: At each message end, `byte_count_o` takes the number of bytes in that message. It holds that value until the next message ends.
- R5: Each message end sets a done latch. `done_irq_o` equals the latch ANDed with `done_ie_i` and `master_ie_i`, and a `done_clr_i` pulse clears the latch.
- R6: When `start_clr_en_i` is 1 at a message end, `rx_enabled_o` drops to 0. Otherwise the receiver stays enabled for the next start bit.
- R7: A falling edge whose line is high again at mid-bit is rejected. It produces no character and does not start a message.
- R8: A parity mismatch sets the sticky `rx_err_o`. The parity rule is: with `parity_odd_i`=0 the data bits plus the parity bit hold an even number of ones, and with `parity_odd_i`=1 an odd number. A low stop bit also sets `rx_err_o`. Only a `err_clr_i` pulse clears it.
- R9: A word that meets `fifo_full_i`=1 is dropped, with no `fifo_wr_o`, and sets the overflow latch. `ovf_irq_o` equals the latch ANDed with `ovf_ie_i` and `master_ie_i`, and `ovf_clr_i` clears the latch.
- R10: `word_count_o` equals `fifo_count_i` plus one for a partly filled word plus one for a word waiting to be written. `almost_full_o` is 1 exactly when `word_count_o` >= `afl_lvl_i`.
- R11: One bit time is `div_i` (bit 0 forced to 0, minimum 2) strobes of the reference tick chosen by `ref_sel_i`.
- R12: While disabled, the receiver ignores the line: no characters, no FIFO writes, no message end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| ref_tick_i | input | NUM_REFS | Reference tick strobes, one per source |
| ref_sel_i | input | SEL_W | Reference source select |
| div_i | input | DIV_W | Bit time in reference ticks (even) |
| gap_bits_i | input | GAP_W | Idle bit times that end a message (0 treated as 1) |
| parity_en_i | input | 1 | Parity bit present |
| parity_odd_i | input | 1 | Odd parity when 1, even when 0 |
| two_stop_i | input | 1 | Two stop bits when 1 |
| en_set_i | input | 1 | Enable pulse |
| en_clr_i | input | 1 | Disable pulse |
| start_clr_en_i | input | 1 | Drop the enable at message end |
| afl_lvl_i | input | CNT_W | Almost-full level |
| master_ie_i | input | 1 | Master interrupt enable |
| done_ie_i | input | 1 | Done interrupt enable |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| done_clr_i | input | 1 | Clear done latch |
| ovf_clr_i | input | 1 | Clear overflow latch |
| err_clr_i | input | 1 | Clear error status |
| fifo_full_i | input | 1 | Receive FIFO full |
| fifo_count_i | input | CNT_W | Receive FIFO word count |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 8*WORD_BYTES | FIFO write data |
| rx_enabled_o | output | 1 | Receiver enabled |
| byte_count_o | output | BCNT_W | Bytes in last message |
| word_count_o | output | CNT_W | Words in FIFO plus packing stage |
| almost_full_o | output | 1 | Word count at or above level |
| done_irq_o | output | 1 | Message done interrupt |
| ovf_irq_o | output | 1 | Overflow interrupt |
| rx_err_o | output | 1 | Sticky parity or stop error |

## Verification
The bench keeps the default parameters: two reference sources, 4-byte words, a 4-bit gap field and 12-bit counts. It drives source 0 every clock and source 1 every other clock. With `div_i`=4 and `gap_bits_i`=4, a bit takes 4 or 8 clocks, so a full character, a message end and a glitch fit in a few dozen cycles. That keeps byte packing, zero padding, count hold across messages, rejected start bits, parity and stop errors, overflow drops and the almost-full compare all cheap to reach. Driving `fifo_full_i` and `fifo_count_i` directly lets overflow and the level compare be set in any cycle.

// File: rtl/msg_uart_rx_pkg.sv
package msg_uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
  } rx_char_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[0] <= 1'b1;
        else         sr_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[g] <= 1'b1;
        else         sr_q[g] <= sr_q[g-1];
      end
    end
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rx_tick_sel.sv
module rx_tick_sel #(
  parameter int NUM_REFS = 2,
  parameter int DIV_W    = 6,
  localparam int SEL_W   = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1
) (
  input  logic [NUM_REFS-1:0] ref_tick_i,
  input  logic [SEL_W-1:0]    ref_sel_i,
  input  logic [DIV_W-1:0]    div_i,
  output logic                tick_o,
  output logic [DIV_W-1:0]    per_o,
  output logic [DIV_W-1:0]    half_o
);
  logic [DIV_W-1:0] even_div;

  always_comb begin
    tick_o = 1'b0;
    for (int i = 0; i < NUM_REFS; i++) begin
      if (SEL_W'(i) == ref_sel_i) tick_o = ref_tick_i[i];
    end
  end

  assign even_div = {div_i[DIV_W-1:1], 1'b0};
  assign per_o    = (even_div < DIV_W'(2)) ? DIV_W'(2) : even_div;
  assign half_o   = per_o >> 1;
endmodule

// File: rtl/rx_char_fsm.sv
module rx_char_fsm
  import msg_uart_rx_pkg::*;
#(
  parameter int DIV_W = 6,
  parameter int GAP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             line_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] per_i,
  input  logic [DIV_W-1:0] half_i,
  input  logic             parity_en_i,
  input  logic             parity_odd_i,
  input  logic             two_stop_i,
  input  logic [GAP_W-1:0] gap_bits_i,
  output logic             char_v_o,
  output rx_char_t         char_o,
  output logic             eom_o
);
  rx_state_e        st_q;
  logic [DIV_W-1:0] tcnt_q, gap_t_q;
  logic [GAP_W-1:0] gap_b_q, gap_lim;
  logic [2:0]       bcnt_q;
  logic [7:0]       shreg_q;
  logic             perr_q, ferr_q, line_q, msg_act_q;
  logic             fall, full_bit, half_bit;

  assign fall     = line_q & ~line_i;
  assign full_bit = tick_i && ((tcnt_q + DIV_W'(1)) == per_i);
  assign half_bit = tick_i && ((tcnt_q + DIV_W'(1)) == half_i);
  assign gap_lim  = (gap_bits_i == '0) ? GAP_W'(1) : gap_bits_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      tcnt_q    <= '0;
      gap_t_q   <= '0;
      gap_b_q   <= '0;
      bcnt_q    <= '0;
      shreg_q   <= '0;
      perr_q    <= 1'b0;
      ferr_q    <= 1'b0;
      line_q    <= 1'b1;
      msg_act_q <= 1'b0;
      char_v_o  <= 1'b0;
      char_o    <= '0;
      eom_o     <= 1'b0;
    end else begin
      line_q   <= line_i;
      char_v_o <= 1'b0;
      eom_o    <= 1'b0;
      if (!en_i) begin
        st_q    <= ST_IDLE;
        tcnt_q  <= '0;
        gap_t_q <= '0;
        gap_b_q <= '0;
      end else begin
        case (st_q)
          ST_IDLE: begin
            if (fall) begin
              st_q    <= ST_START;
              tcnt_q  <= '0;
              gap_t_q <= '0;
              gap_b_q <= '0;
            end else if (!line_i) begin
              gap_t_q <= '0;
              gap_b_q <= '0;
            end else if (msg_act_q && tick_i) begin
              if ((gap_t_q + DIV_W'(1)) == per_i) begin
                gap_t_q <= '0;
                if ((gap_b_q + GAP_W'(1)) == gap_lim) begin
                  gap_b_q   <= '0;
                  eom_o     <= 1'b1;
                  msg_act_q <= 1'b0;
                end else begin
                  gap_b_q <= gap_b_q + GAP_W'(1);
                end
              end else begin
                gap_t_q <= gap_t_q + DIV_W'(1);
              end
            end
          end
          ST_START: begin
            if (half_bit) begin
              tcnt_q <= '0;
              bcnt_q <= '0;
              perr_q <= 1'b0;
              ferr_q <= 1'b0;
              st_q   <= line_i ? ST_IDLE : ST_DATA;
            end else if (tick_i) begin
              tcnt_q <= tcnt_q + DIV_W'(1);
            end
          end
          ST_DATA: begin
            if (full_bit) begin
              tcnt_q  <= '0;
              shreg_q <= {line_i, shreg_q[7:1]};
              if (bcnt_q == 3'd7) st_q <= parity_en_i ? ST_PAR : ST_STOP1;
              bcnt_q <= bcnt_q + 3'd1;
            end else if (tick_i) begin
              tcnt_q <= tcnt_q + DIV_W'(1);
            end
          end
          ST_PAR: begin
            if (full_bit) begin
              tcnt_q <= '0;
              perr_q <= (^{shreg_q, line_i}) ^ parity_odd_i;
              st_q   <= ST_STOP1;
            end else if (tick_i) begin
              tcnt_q <= tcnt_q + DIV_W'(1);
            end
          end
          ST_STOP1, ST_STOP2: begin
            if (full_bit) begin
              tcnt_q <= '0;
              if (st_q == ST_STOP1 && two_stop_i) begin
                ferr_q <= ~line_i;
                st_q   <= ST_STOP2;
              end else begin
                char_v_o    <= 1'b1;
                char_o.data <= shreg_q;
                char_o.perr <= perr_q;
                char_o.ferr <= ferr_q | ~line_i;
                msg_act_q   <= 1'b1;
                gap_t_q     <= '0;
                gap_b_q     <= '0;
                st_q        <= ST_IDLE;
              end
            end else if (tick_i) begin
              tcnt_q <= tcnt_q + DIV_W'(1);
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_word_packer.sv
module rx_word_packer #(
  parameter int WORD_BYTES = 4,
  parameter int BCNT_W     = 16,
  localparam int WORD_W    = 8 * WORD_BYTES,
  localparam int FILL_W    = $clog2(WORD_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_v_i,
  input  logic [7:0]        char_i,
  input  logic              eom_i,
  input  logic              fifo_full_i,
  output logic              fifo_wr_o,
  output logic [WORD_W-1:0] fifo_data_o,
  output logic              ovf_o,
  output logic              pend_o,
  output logic              push_o,
  output logic [BCNT_W-1:0] byte_count_o,
  output logic              done_o
);
  logic [WORD_W-1:0] lanes_q, word_d;
  logic [FILL_W-1:0] fill_q;
  logic [BCNT_W-1:0] msg_bytes_q;
  logic              push_d, push_q;

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign word_d[g*8 +: 8] = (char_v_i && fill_q == FILL_W'(g)) ? char_i : lanes_q[g*8 +: 8];
  end

  assign push_d = (char_v_i && fill_q == FILL_W'(WORD_BYTES - 1)) ||
                  (eom_i && fill_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lanes_q      <= '0;
      fill_q       <= '0;
      push_q       <= 1'b0;
      fifo_data_o  <= '0;
      msg_bytes_q  <= '0;
      byte_count_o <= '0;
      done_o       <= 1'b0;
    end else begin
      push_q <= push_d;
      done_o <= eom_i;
      if (push_d) fifo_data_o <= word_d;
      if (push_d || eom_i) begin
        lanes_q <= '0;
        fill_q  <= '0;
      end else if (char_v_i) begin
        lanes_q <= word_d;
        fill_q  <= fill_q + FILL_W'(1);
      end
      if (eom_i) begin
        byte_count_o <= msg_bytes_q;
        msg_bytes_q  <= '0;
      end else if (char_v_i) begin
        msg_bytes_q <= msg_bytes_q + BCNT_W'(1);
      end
    end
  end

  assign fifo_wr_o = push_q & ~fifo_full_i;
  assign ovf_o     = push_q & fifo_full_i;
  assign pend_o    = (fill_q != '0);
  assign push_o    = push_q;
endmodule

// File: rtl/msg_uart_rx.sv
module msg_uart_rx
  import msg_uart_rx_pkg::*;
#(
  parameter int NUM_REFS    = 2,
  parameter int DIV_W       = 6,
  parameter int GAP_W       = 4,
  parameter int WORD_BYTES  = 4,
  parameter int CNT_W       = 12,
  parameter int BCNT_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1,
  localparam int WORD_W     = 8 * WORD_BYTES
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_i,
  input  logic [NUM_REFS-1:0] ref_tick_i,
  input  logic [SEL_W-1:0]    ref_sel_i,
  input  logic [DIV_W-1:0]    div_i,
  input  logic [GAP_W-1:0]    gap_bits_i,
  input  logic                parity_en_i,
  input  logic                parity_odd_i,
  input  logic                two_stop_i,
  input  logic                en_set_i,
  input  logic                en_clr_i,
  input  logic                start_clr_en_i,
  input  logic [CNT_W-1:0]    afl_lvl_i,
  input  logic                master_ie_i,
  input  logic                done_ie_i,
  input  logic                ovf_ie_i,
  input  logic                done_clr_i,
  input  logic                ovf_clr_i,
  input  logic                err_clr_i,
  input  logic                fifo_full_i,
  input  logic [CNT_W-1:0]    fifo_count_i,
  output logic                fifo_wr_o,
  output logic [WORD_W-1:0]   fifo_data_o,
  output logic                rx_enabled_o,
  output logic [BCNT_W-1:0]   byte_count_o,
  output logic [CNT_W-1:0]    word_count_o,
  output logic                almost_full_o,
  output logic                done_irq_o,
  output logic                ovf_irq_o,
  output logic                rx_err_o
);
  logic             line_w, tick_w, char_v_w, eom_w, ovf_w, pend_w, push_w, done_w;
  logic [DIV_W-1:0] per_w, half_w;
  rx_char_t         char_w;
  logic             en_q, done_q, ovf_q, err_q;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_i), .q_o(line_w)
  );

  rx_tick_sel #(.NUM_REFS(NUM_REFS), .DIV_W(DIV_W)) u_tick (
    .ref_tick_i(ref_tick_i), .ref_sel_i(ref_sel_i), .div_i(div_i),
    .tick_o(tick_w), .per_o(per_w), .half_o(half_w)
  );

  rx_char_fsm #(.DIV_W(DIV_W), .GAP_W(GAP_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_q), .line_i(line_w),
    .tick_i(tick_w), .per_i(per_w), .half_i(half_w),
    .parity_en_i(parity_en_i), .parity_odd_i(parity_odd_i),
    .two_stop_i(two_stop_i), .gap_bits_i(gap_bits_i),
    .char_v_o(char_v_w), .char_o(char_w), .eom_o(eom_w)
  );

  rx_word_packer #(.WORD_BYTES(WORD_BYTES), .BCNT_W(BCNT_W)) u_pack (
    .clk_i(clk_i), .rst_ni(rst_ni), .char_v_i(char_v_w), .char_i(char_w.data),
    .eom_i(eom_w), .fifo_full_i(fifo_full_i), .fifo_wr_o(fifo_wr_o),
    .fifo_data_o(fifo_data_o), .ovf_o(ovf_w), .pend_o(pend_w), .push_o(push_w),
    .byte_count_o(byte_count_o), .done_o(done_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (en_set_i)                                  en_q <= 1'b1;
      else if (en_clr_i || (eom_w && start_clr_en_i)) en_q <= 1'b0;
      if (done_w)          done_q <= 1'b1;
      else if (done_clr_i) done_q <= 1'b0;
      if (ovf_w)           ovf_q <= 1'b1;
      else if (ovf_clr_i)  ovf_q <= 1'b0;
      if (char_v_w && (char_w.perr || char_w.ferr)) err_q <= 1'b1;
      else if (err_clr_i)                          err_q <= 1'b0;
    end
  end

  assign rx_enabled_o  = en_q;
  assign word_count_o  = fifo_count_i + CNT_W'(pend_w) + CNT_W'(push_w);
  assign almost_full_o = (word_count_o >= afl_lvl_i);
  assign done_irq_o    = done_q & done_ie_i & master_ie_i;
  assign ovf_irq_o     = ovf_q & ovf_ie_i & master_ie_i;
  assign rx_err_o      = err_q;
endmodule

// File: rtl/msg_uart_rx_chk.sv
module msg_uart_rx_chk #(
  parameter int CNT_W  = 12,
  parameter int BCNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fifo_wr_o,
  input logic              fifo_full_i,
  input logic              done_irq_o,
  input logic              done_ie_i,
  input logic              master_ie_i,
  input logic              ovf_irq_o,
  input logic              ovf_ie_i,
  input logic [CNT_W-1:0]  word_count_o,
  input logic [CNT_W-1:0]  fifo_count_i,
  input logic [BCNT_W-1:0] byte_count_o,
  input logic              eom_i,
  input logic              start_clr_en_i,
  input logic              en_set_i,
  input logic              rx_enabled_o,
  input logic              rx_err_o,
  input logic              err_clr_i
);
  AST_WR_NOT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> !fifo_full_i); // R9

  AST_OVF_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_irq_o |-> (ovf_ie_i && master_ie_i)); // R9

  AST_DONE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |-> (done_ie_i && master_ie_i)); // R5

  AST_BYTE_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eom_i |=> $stable(byte_count_o)); // R4

  AST_SELF_DISABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eom_i && start_clr_en_i && !en_set_i) |=> !rx_enabled_o); // R6

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_err_o && !err_clr_i) |=> rx_err_o); // R8

  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, word_count_o} >= {1'b0, fifo_count_i}) &&
    ({1'b0, word_count_o} <= {1'b0, fifo_count_i} + (CNT_W+1)'(2))); // R10
endmodule

bind msg_uart_rx msg_uart_rx_chk #(.CNT_W(CNT_W), .BCNT_W(BCNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fifo_wr_o(fifo_wr_o), .fifo_full_i(fifo_full_i),
  .done_irq_o(done_irq_o), .done_ie_i(done_ie_i), .master_ie_i(master_ie_i),
  .ovf_irq_o(ovf_irq_o), .ovf_ie_i(ovf_ie_i), .word_count_o(word_count_o),
  .fifo_count_i(fifo_count_i), .byte_count_o(byte_count_o), .eom_i(eom_w),
  .start_clr_en_i(start_clr_en_i), .en_set_i(en_set_i), .rx_enabled_o(rx_enabled_o),
  .rx_err_o(rx_err_o), .err_clr_i(err_clr_i)
);

// File: tb/tb_msg_uart_rx.sv
module tb_msg_uart_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b1;
  logic [1:0]  ref_tick;
  logic        ref_b = 1'b0;
  logic        ref_sel = 1'b0;
  logic [5:0]  div = 6'd4;
  logic [3:0]  gap = 4'd4;
  logic        par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
  logic        en_set = 1'b0, en_clr = 1'b0, sclr = 1'b0;
  logic [11:0] afl = 12'd100;
  logic        mie = 1'b1, die = 1'b1, oie = 1'b1;
  logic        dclr = 1'b0, oclr = 1'b0, eclr = 1'b0;
  logic        ffull = 1'b0;
  logic [11:0] fcnt = 12'd0;
  logic        wr;
  logic [31:0] wdata;
  logic        en_o, afull, dirq, oirq, err;
  logic [15:0] bcnt;
  logic [11:0] wcnt;

  int checks = 0, fails = 0, wn = 0;
  logic [31:0] wq [64];

  always #4 clk = ~clk;
  always @(posedge clk) ref_b <= ~ref_b;
  assign ref_tick = {ref_b, 1'b1};

  msg_uart_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .ref_tick_i(ref_tick), .ref_sel_i(ref_sel),
    .div_i(div), .gap_bits_i(gap), .parity_en_i(par_en), .parity_odd_i(par_odd),
    .two_stop_i(two_stop), .en_set_i(en_set), .en_clr_i(en_clr), .start_clr_en_i(sclr),
    .afl_lvl_i(afl), .master_ie_i(mie), .done_ie_i(die), .ovf_ie_i(oie),
    .done_clr_i(dclr), .ovf_clr_i(oclr), .err_clr_i(eclr), .fifo_full_i(ffull),
    .fifo_count_i(fcnt), .fifo_wr_o(wr), .fifo_data_o(wdata), .rx_enabled_o(en_o),
    .byte_count_o(bcnt), .word_count_o(wcnt), .almost_full_o(afull),
    .done_irq_o(dirq), .ovf_irq_o(oirq), .rx_err_o(err)
  );

  always @(posedge clk) if (wr && wn < 64) begin wq[wn] = wdata; wn = wn + 1; end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit bad_par = 0, input bit bad_stop = 0);
    int bc;
    bc = ref_sel ? 2 * div : div;
    @(negedge clk);
    rx = 1'b0; cyc(bc);
    for (int i = 0; i < 8; i++) begin rx = b[i]; cyc(bc); end
    if (par_en) begin rx = (^b) ^ par_odd ^ bad_par; cyc(bc); end
    rx = ~bad_stop; cyc(bc);
    if (two_stop) begin rx = 1'b1; cyc(bc); end
    rx = 1'b1;
  endtask

  task automatic t_reset();
    chk(en_o == 0, "R1 enable", en_o, 0);
    chk(bcnt == 0 && dirq == 0 && oirq == 0 && err == 0, "R1 outputs",
        {bcnt, dirq, oirq, err}, 0);
    chk(wn == 0, "R1 no write", wn, 0);
  endtask

  task automatic t_disabled();
    send_byte(8'h5A); cyc(60);
    chk(wn == 0 && bcnt == 0 && dirq == 0, "R12 ignored while disabled", wn, 0);
  endtask

  task automatic t_full_word();
    pulse(en_set);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
    cyc(4);
    chk(wn == 1, "R2 word count", wn, 1);
    chk(wq[0] == 32'h44332211, "R2 packing", wq[0], 32'h44332211);
    cyc(40);
    chk(wn == 1, "R3 no pad write when empty", wn, 1);
    chk(bcnt == 4, "R4 byte count", bcnt, 4);
    chk(dirq == 1, "R5 done irq", dirq, 1);
    chk(en_o == 1, "R6 stays enabled", en_o, 1);
    die = 1'b0; @(negedge clk);
    chk(dirq == 0, "R5 done gated", dirq, 0);
    die = 1'b1; pulse(dclr); @(negedge clk);
    chk(dirq == 0, "R5 done cleared", dirq, 0);
  endtask

  task automatic t_partial();
    int base;
    base = wn;
    for (int i = 1; i <= 5; i++) send_byte(8'hA0 + 8'(i));
    cyc(40);
    chk(wn == base + 2, "R3 partial flush count", wn, base + 2);
    chk(wq[base+1] == 32'h000000A5, "R3 zero padding", wq[base+1], 32'h000000A5);
    chk(bcnt == 5, "R4 byte count 5", bcnt, 5);
    send_byte(8'hC3); cyc(2);
    chk(bcnt == 5, "R4 held until next end", bcnt, 5);
    cyc(40);
    chk(bcnt == 1 && wq[base+2] == 32'h000000C3, "R4 updated", bcnt, 1);
    pulse(dclr);
  endtask

  task automatic t_glitch();
    int base;
    base = wn;
    @(negedge clk); rx = 1'b0; @(negedge clk); rx = 1'b1;
    cyc(80);
    chk(wn == base && bcnt == 1 && dirq == 0, "R7 glitch rejected", wn, base);
  endtask

  task automatic t_level();
    fcnt = 12'd5; afl = 12'd5; @(negedge clk);
    chk(afull == 1 && wcnt == 5, "R10 at level", {afull, wcnt}, {1'b1, 12'd5});
    afl = 12'd6; @(negedge clk);
    chk(afull == 0, "R10 below level", afull, 0);
    send_byte(8'h77); cyc(4);
    chk(wcnt == 6 && afull == 1, "R10 partial word counted", wcnt, 6);
    cyc(40);
    chk(wcnt == 5, "R10 after flush", wcnt, 5);
    fcnt = 12'd0; afl = 12'd100; pulse(dclr);
  endtask

  task automatic t_refsel();
    int base;
    base = wn;
    ref_sel = 1'b1;
    send_byte(8'hAA); send_byte(8'hBB);
    cyc(80);
    chk(wn == base + 1 && wq[base] == 32'h0000BBAA, "R11 slow reference", wq[base], 32'h0000BBAA);
    ref_sel = 1'b0; pulse(dclr);
  endtask

  task automatic t_errors();
    par_en = 1'b1;
    send_byte(8'h03); cyc(40);
    chk(err == 0, "R8 good even parity", err, 0);
    send_byte(8'h03, 1); cyc(40);
    chk(err == 1, "R8 bad parity", err, 1);
    cyc(20);
    chk(err == 1, "R8 sticky", err, 1);
    pulse(eclr); @(negedge clk);
    chk(err == 0, "R8 cleared", err, 0);
    par_odd = 1'b1; two_stop = 1'b1;
    send_byte(8'h07); cyc(40);
    chk(err == 0, "R8 good odd parity two stop", err, 0);
    par_en = 1'b0; par_odd = 1'b0; two_stop = 1'b0;
    send_byte(8'h55, 0, 1); cyc(40);
    chk(err == 1, "R8 stop error", err, 1);
    pulse(eclr); pulse(dclr);
  endtask

  task automatic t_overflow();
    int base;
    base = wn;
    ffull = 1'b1;
    for (int i = 0; i < 4; i++) send_byte(8'h90 + 8'(i));
    cyc(40);
    chk(wn == base, "R9 word dropped", wn, base);
    chk(oirq == 1, "R9 overflow irq", oirq, 1);
    mie = 1'b0; @(negedge clk);
    chk(oirq == 0, "R9 master gate", oirq, 0);
    mie = 1'b1; ffull = 1'b0; pulse(oclr); @(negedge clk);
    chk(oirq == 0, "R9 cleared", oirq, 0);
    pulse(dclr);
  endtask

  task automatic t_self_disable();
    int base;
    base = wn;
    sclr = 1'b1;
    send_byte(8'hE1); cyc(40);
    chk(en_o == 0, "R6 self disable", en_o, 0);
    send_byte(8'hE2); cyc(40);
    chk(wn == base + 1, "R12 after self disable", wn, base + 1);
    sclr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1'b1; cyc(2);
    t_reset();
    t_disabled();
    t_full_word();
    t_partial();
    t_glitch();
    t_level();
    t_refsel();
    t_errors();
    t_overflow();
    t_self_disable();
    summary();
    $finish;
  end
endmodule